// File: doc/BRIEF.md
# Masked Variable Byte Permute Unit

This block is a byte-shuffle datapath for vectors of up to 512 bits. Every destination byte lane picks one byte out of a data vector. The position of that byte comes from the matching byte of a separate index vector. Any data byte may feed any number of destination lanes.

A two-bit length code selects how much of the vector is active: 16, 32 or 64 byte lanes. The code also sets how many low index bits are honoured. A per-lane mask can be switched on. With the mask on, a lane whose mask bit is clear either keeps the previous destination byte (merge) or becomes zero (zeroing). Lanes at or above the active length are always cleared.

The result is registered. It appears one clock after a valid input strobe. A small two-state controller tracks whether the output holds a fresh result:

- `ST_IDLE`: no fresh result is held.
- `ST_DONE`: a result was loaded on the last edge.

The controller moves between these states as follows:

- `IDLE->DONE` on a strobe.
- `DONE->DONE` on another strobe.
- `DONE->IDLE` when no strobe arrives.

Top module: `vbp_permute_unit`

## Requirements
- R1: Byte lane j of a vector is bits [8j+7:8j]. Output lane j equals the data-vector byte at the position given by index byte j, after index truncation. One data byte may appear in several output lanes.
- R2: Only the low bits of each index byte are used: 4 bits for length code 0 (128-bit), 5 bits for code 1 (256-bit) and 6 bits for code 2 (512-bit). The remaining index bits have no effect on the result.
- R3: Length code 3 behaves exactly like code 2: 64 active lanes and 6 index bits.
- R4: With `mask_en` low, every active lane receives its selected byte, whatever `lane_mask` holds.
- R5: With `mask_en` high and `zero_mode` high, an active lane j whose `lane_mask` bit j is 0 becomes 0x00.
- R6: With `mask_en` high and `zero_mode` low, an active lane j whose `lane_mask` bit j is 0 takes byte j of `old_dst`.
- R7: Every output lane at or above the active lane count (16, 32 or 64) is 0x00, regardless of mask, mode or `old_dst`.
- R8: When `in_valid` is sampled high on a clock edge, the result and a high `out_valid` appear after that edge. When `in_valid` is sampled low, `out_valid` goes low and `out_vec` keeps its value.
- R9: A synchronous active-low reset clears `out_vec` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads a new result |
| len_sel | input | 2 | Length code: 0=128, 1=256, 2 or 3=512 bits |
| mask_en | input | 1 | Enables the per-lane mask |
| zero_mode | input | 1 | 1: masked-off lanes become zero; 0: they merge old_dst |
| lane_mask | input | 64 | Per-lane mask, bit j controls lane j |
| idx_vec | input | 512 | Index bytes, one per lane |
| data_vec | input | 512 | Source bytes to pick from |
| old_dst | input | 512 | Previous destination value used by merging |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_vec | output | 512 | Registered result |

## Verification
The lane pick is driven with an identity index, a full reversal, and a single index broadcast to every lane. Together these separate a correct crossbar from one that passes lanes straight through or cannot duplicate a source byte. Index bytes with their upper bits set are sent at each length code. This shows whether truncation uses the right width, and whether code 3 follows code 2. Alternating mask patterns are sent in both modes, with an all-ones old destination. These tell zeroing apart from merging, and show that lanes above the active length stay clear even when merging would otherwise fill them.

// File: rtl/vbp_pkg.sv
package vbp_pkg;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ost_e;

    // Number of live lanes for a length code; reserved code acts as widest.
    function automatic int unsigned live_lanes(input logic [1:0] code, input int unsigned max_lanes);
        unique case (vlen_e'(code))
            VL_128:  return max_lanes >> 2;
            VL_256:  return max_lanes >> 1;
            default: return max_lanes;
        endcase
    endfunction

endpackage

// File: rtl/vbp_lane_pick.sv
module vbp_lane_pick #(
    parameter int LANES = 64,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic [LANES*8-1:0] data_vec,
    input  logic [7:0]         idx_byte,
    input  logic [1:0]         len_code,
    output logic [7:0]         pick
);
    import vbp_pkg::*;

    logic [7:0] keep_bits;
    logic [7:0] idx_m;
    logic [7:0] src_bytes [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_view
        assign src_bytes[k] = data_vec[k*8 +: 8];
    end

    always_comb begin
        unique case (vlen_e'(len_code))
            VL_128:  keep_bits = 8'((1 << (IDXW - 2)) - 1);
            VL_256:  keep_bits = 8'((1 << (IDXW - 1)) - 1);
            default: keep_bits = 8'((1 << IDXW) - 1);
        endcase
        idx_m = idx_byte & keep_bits;
    end

    always_comb begin
        pick = 8'h00;
        for (int k = 0; k < LANES; k++) begin
            if (idx_m == 8'(k)) pick = src_bytes[k];
        end
    end

endmodule

// File: rtl/vbp_lane_finish.sv
module vbp_lane_finish (
    input  logic [7:0] pick,
    input  logic [7:0] old_byte,
    input  logic       lane_live,
    input  logic       mask_bit,
    input  logic       mask_en,
    input  logic       zero_mode,
    output logic [7:0] out_byte
);
    always_comb begin
        if (!lane_live)                 out_byte = 8'h00;
        else if (!mask_en || mask_bit)  out_byte = pick;
        else if (zero_mode)             out_byte = 8'h00;
        else                            out_byte = old_byte;
    end
endmodule

// File: rtl/vbp_out_ctrl.sv
module vbp_out_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load,
    output logic out_valid
);
    import vbp_pkg::*;

    ost_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_DONE);
        load      = in_valid;
    end

endmodule

// File: rtl/vbp_permute_unit.sv
module vbp_permute_unit #(
    parameter int LANES = 64,
    localparam int VW = LANES * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      len_sel,
    input  logic            mask_en,
    input  logic            zero_mode,
    input  logic [LANES-1:0] lane_mask,
    input  logic [VW-1:0]   idx_vec,
    input  logic [VW-1:0]   data_vec,
    input  logic [VW-1:0]   old_dst,
    output logic            out_valid,
    output logic [VW-1:0]   out_vec
);
    import vbp_pkg::*;

    logic [VW-1:0]    next_vec;
    logic [LANES-1:0] live;
    logic             load;
    int unsigned      n_live;

    assign n_live = live_lanes(len_sel, LANES);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [7:0] picked;

        assign live[j] = (j < n_live);

        vbp_lane_pick #(.LANES(LANES)) u_pick (
            .data_vec (data_vec),
            .idx_byte (idx_vec[j*8 +: 8]),
            .len_code (len_sel),
            .pick     (picked)
        );

        vbp_lane_finish u_fin (
            .pick      (picked),
            .old_byte  (old_dst[j*8 +: 8]),
            .lane_live (live[j]),
            .mask_bit  (lane_mask[j]),
            .mask_en   (mask_en),
            .zero_mode (zero_mode),
            .out_byte  (next_vec[j*8 +: 8])
        );
    end

    vbp_out_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .load      (load),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    out_vec <= '0;
        else if (load) out_vec <= next_vec;
    end

endmodule

// File: rtl/vbp_permute_unit_chk.sv
module vbp_permute_unit_chk #(
    parameter int LANES = 64,
    localparam int VW = LANES * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       len_sel,
    input logic             mask_en,
    input logic             zero_mode,
    input logic [LANES-1:0] lane_mask,
    input logic             out_valid,
    input logic [VW-1:0]    out_vec
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec)); // R8

    AST_UPPER_QUARTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel == 2'd0) |=> (out_vec[VW-1:VW/4] == '0)); // R7

    AST_UPPER_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && len_sel == 2'd1) |=> (out_vec[VW-1:VW/2] == '0)); // R7

    AST_ALL_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_mode && lane_mask == '0) |=> (out_vec == '0)); // R5
endmodule

bind vbp_permute_unit vbp_permute_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .len_sel   (len_sel),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .lane_mask (lane_mask),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/vbp_permute_unit_tb.sv
module vbp_permute_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   len_sel;
    logic         mask_en;
    logic         zero_mode;
    logic [63:0]  lane_mask;
    logic [511:0] idx_vec, data_vec, old_dst;
    logic         out_valid;
    logic [511:0] out_vec;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    vbp_permute_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .len_sel(len_sel),
        .mask_en(mask_en), .zero_mode(zero_mode), .lane_mask(lane_mask),
        .idx_vec(idx_vec), .data_vec(data_vec), .old_dst(old_dst),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [511:0] model(input logic [1:0] len, input logic men,
                                           input logic zm, input logic [63:0] m,
                                           input logic [511:0] idx, input logic [511:0] d,
                                           input logic [511:0] old);
        logic [511:0] r;
        int lanes;
        int id;
        lanes = (len == 2'd0) ? 16 : (len == 2'd1) ? 32 : 64;
        r = '0;
        for (int j = 0; j < lanes; j++) begin
            id = int'(idx[j*8 +: 8]) % lanes;
            if (!men || m[j])  r[j*8 +: 8] = d[id*8 +: 8];
            else if (zm)       r[j*8 +: 8] = 8'h00;
            else               r[j*8 +: 8] = old[j*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk_vec(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: out_vec actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [511:0] fill_data(input int seed);
        logic [511:0] v;
        for (int k = 0; k < 64; k++) v[k*8 +: 8] = 8'(k * 37 + seed * 11 + 5);
        return v;
    endfunction

    // Drive one operation, then check the result after the loading edge.
    task automatic run_op(input string req, input logic [1:0] len, input logic men,
                          input logic zm, input logic [63:0] m, input logic [511:0] idx,
                          input logic [511:0] d, input logic [511:0] old,
                          input logic [1:0] model_len);
        @(negedge clk);
        in_valid = 1'b1; len_sel = len; mask_en = men; zero_mode = zm;
        lane_mask = m; idx_vec = idx; data_vec = d; old_dst = old;
        @(posedge clk); #1;
        chk_bit({req, " out_valid"}, out_valid, 1'b1);
        chk_vec(req, out_vec, model(model_len, men, zm, m, idx, d, old));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; len_sel = 2'd2; mask_en = 1'b0; zero_mode = 1'b0;
        lane_mask = '0; idx_vec = '0; data_vec = '0; old_dst = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_bit("R9 out_valid in reset", out_valid, 1'b0);
        chk_vec("R9 out_vec in reset", out_vec, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_identity();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(j);
        run_op("R1 identity", 2'd2, 1'b0, 1'b0, '0, idx, fill_data(1), '0, 2'd2);
    endtask

    task automatic t_reverse();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(63 - j);
        run_op("R1 reverse", 2'd2, 1'b1, 1'b0, '1, idx, fill_data(2), '0, 2'd2);
    endtask

    task automatic t_broadcast();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'd5;
        run_op("R1 broadcast", 2'd2, 1'b0, 1'b0, '0, idx, fill_data(3), '0, 2'd2);
    endtask

    task automatic t_trunc(input logic [1:0] len, input string req);
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(((j * 13) & 8'h3f) | 8'hc0) ^ 8'(j & 8'h30);
        run_op(req, len, 1'b0, 1'b0, '0, idx, fill_data(4), '1, len);
    endtask

    task automatic t_code3();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'((j * 29 + 7) | 8'h40);
        run_op("R3 code 3 like 512", 2'd3, 1'b0, 1'b0, '0, idx, fill_data(5), '0, 2'd2);
    endtask

    task automatic t_nomask();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(j ^ 8'h2a);
        run_op("R4 mask ignored when off", 2'd2, 1'b0, 1'b1, 64'h0, idx, fill_data(6), '1, 2'd2);
    endtask

    task automatic t_zeroing();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(j * 3);
        run_op("R5 zeroing", 2'd2, 1'b1, 1'b1, 64'haaaa_5555_f0f0_0f0f, idx, fill_data(7), '1, 2'd2);
    endtask

    task automatic t_merge();
        logic [511:0] idx, old;
        for (int j = 0; j < 64; j++) begin
            idx[j*8 +: 8] = 8'(j * 5 + 1);
            old[j*8 +: 8] = 8'(8'h80 | j);
        end
        run_op("R6 merge", 2'd2, 1'b1, 1'b0, 64'h5555_aaaa_0ff0_c3c3, idx, fill_data(8), old, 2'd2);
    endtask

    task automatic t_upper_clear();
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(j);
        run_op("R7 upper clear 256 merge", 2'd1, 1'b1, 1'b0, 64'h0, idx, fill_data(9), '1, 2'd1);
        run_op("R7 upper clear 128 full mask", 2'd0, 1'b1, 1'b1, '1, idx, fill_data(10), '1, 2'd0);
    endtask

    task automatic t_hold();
        logic [511:0] held;
        logic [511:0] idx;
        for (int j = 0; j < 64; j++) idx[j*8 +: 8] = 8'(j + 1);
        run_op("R8 load", 2'd2, 1'b0, 1'b0, '0, idx, fill_data(11), '0, 2'd2);
        held = out_vec;
        @(negedge clk);
        data_vec = fill_data(12); idx_vec = '0;
        @(posedge clk); #1;
        chk_bit("R8 valid drops", out_valid, 1'b0);
        chk_vec("R8 output held", out_vec, held);
    endtask

    task automatic t_midreset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk_bit("R9 valid after reset", out_valid, 1'b0);
        chk_vec("R9 vec after reset", out_vec, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_identity();
        t_reverse();
        t_broadcast();
        t_trunc(2'd0, "R2 trunc 128");
        t_trunc(2'd1, "R2 trunc 256");
        t_trunc(2'd2, "R2 trunc 512");
        t_code3();
        t_nomask();
        t_zeroing();
        t_merge();
        t_upper_clear();
        t_hold();
        t_midreset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule